// File: doc/BRIEF.md
# Serial Command Decoder for a Quad Code Register Bank

This block is the digital front of a four-channel converter. It listens on a three-wire serial slave port (select, serial clock, data in) plus a data-out line with its own output enable, and turns each 14-bit command word into an action on a bank of live registers or on a small persistent store. The bank has four 8-bit channel codes and one control byte that holds per-channel mute and shutdown flags. The persistent store lives outside the block. The block reaches it through a request/acknowledge port that it holds steady until the store responds.

The serial pins are not used as clocks. They pass through synchronizers into the system clock domain, and the rising edges of the serial clock are found by comparing samples. This means the serial clock must run well below the system clock. Each word has a start bit, a 2-bit opcode, a 3-bit address and an 8-bit payload. The four opcodes are: write a live register, store the payload into the persistent store, read a persistent byte back onto data out, and load a persistent byte into the live bank. Each channel reports a 2-bit output state that the analog side decodes. An asynchronous mute pin overrides the register flags.

Top module: `sdac_serial_decoder`

## Requirements
- R1: A word is 14 bits, MSB first: start, opcode bit 1, opcode bit 0, address bits 2..0, then payload bits 7..0. A word whose start bit is 0 has no effect on any register or on the persistent store.
- R2: Opcode 01 with address 0..3 writes the payload into that channel's code when the 14th bit is sampled. The other channels keep their codes. The codes appear on `dac_code_o` with channel n at bits [8n+7:8n].
- R3: Opcode 01 with address 4 writes the control byte. Payload bit 4+n mutes channel n and payload bit n shuts channel n down. The state of channel n appears on `ch_state_o[2n+1:2n]` as 00 active, 01 muted, 10 high impedance.
- R4: Shutdown wins over mute. Changing the flags never alters a code, so a channel returns to its previous code when its mute is cleared.
- R5: While `mute_all_i` is high, every channel that is not shut down reports muted, whatever the control byte holds.
- R6: Opcode 00 writes the payload to persistent address 0..4 with one request that stays stable until it is acknowledged. The live codes and states do not change.
- R7: A store is dropped when every channel in the live control byte is muted, shut down, or both.
- R8: Opcode 10 fetches the persistent byte and drives it MSB first on `sdo_o`. Bit 7-k is valid before the serial-clock rising edge of payload slot k. `sdo_oe_o` is low outside a read frame and falls once select rises. A read changes no live register.
- R9: Opcode 11 copies the persistent byte into the addressed live register when the 14th bit is sampled. The persistent store is not written.
- R10: A frame that ends before 14 bits has no side effect. Addresses 5..7 perform no operation.
- R11: Serial-clock edges seen while select is high are ignored.
- R12: After reset all codes are 0, all channels are active, `sdo_oe_o` is low and no persistent request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, sampled |
| csn_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| mute_all_i | input | 1 | Asynchronous mute of all channels |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| nv_req_o | output | 1 | Persistent store request, held until acknowledge |
| nv_we_o | output | 1 | 1 = write request, 0 = read request |
| nv_addr_o | output | 3 | Persistent address 0..4 |
| nv_wdata_o | output | 8 | Write byte |
| nv_rdata_i | input | 8 | Read byte, valid with acknowledge |
| nv_ack_i | input | 1 | One-cycle acknowledge |
| dac_code_o | output | 32 | Four live channel codes |
| ch_state_o | output | 8 | Four 2-bit channel states |

## Verification
The bench uses the default two-stage synchronizer and holds each serial-clock phase for ten system cycles. The store model acknowledges three cycles after a request. With these values, a fetched byte reaches the data-out register well before the first payload slot, so readback can be compared bit by bit. The slow serial clock also leaves room to check codes, states and persistent contents between frames. Malformed frames (a zero start bit, a truncated word, an unused address, clock edges while deselected) are mixed in with valid traffic, and each one is followed by a readback through the normal port.

// File: rtl/sdac_cmd_pkg.sv
package sdac_cmd_pkg;
  localparam int CODE_W    = 8;
  localparam int NUM_CH    = 4;
  localparam int ADDR_W    = 3;
  localparam int HDR_W     = 6;
  localparam int WORD_W    = HDR_W + CODE_W;
  localparam int CTRL_ADDR = NUM_CH;

  typedef enum logic [1:0] {
    OP_STORE = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_LOAD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CH_ACTIVE = 2'b00,
    CH_MUTED  = 2'b01,
    CH_HIZ    = 2'b10
  } ch_state_e;

  typedef struct packed {
    logic              start;
    op_e               op;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stg
      logic [W-1:0] q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else        q <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else        q <= g_stg[s-1].q;
        end
      end
    end
  endgenerate

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  output logic              hdr_vld_o,
  output hdr_t              hdr_o,
  output logic              dshift_o,
  output logic              word_vld_o,
  output logic [CODE_W-1:0] data_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int SH_W  = WORD_W - 1;
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] D_FIRST   = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] D_SHLAST  = CNT_W'(WORD_W - 2);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic              hdr_vld_q, hdr_vld_n;
  hdr_t              hdr_q, hdr_n;
  logic              dshift_q, dshift_n;
  logic              word_vld_q, word_vld_n;
  logic [CODE_W-1:0] data_q, data_n;
  logic              rise;

  assign rise = sclk_s & ~sclk_q & ~csn_s;

  always_comb begin
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    hdr_n      = hdr_q;
    data_n     = data_q;
    hdr_vld_n  = 1'b0;
    dshift_n   = 1'b0;
    word_vld_n = 1'b0;
    if (csn_s) begin
      cnt_n = '0;
    end else if (rise && (cnt_q <= WORD_LAST)) begin
      sh_n  = {sh_q[SH_W-2:0], sdi_s};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == HDR_LAST) begin
        hdr_vld_n = 1'b1;
        hdr_n     = hdr_t'({sh_q[HDR_W-2:0], sdi_s});
      end
      if ((cnt_q >= D_FIRST) && (cnt_q <= D_SHLAST)) begin
        dshift_n = 1'b1;
      end
      if (cnt_q == WORD_LAST) begin
        word_vld_n = 1'b1;
        data_n     = {sh_q[CODE_W-2:0], sdi_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      hdr_q      <= '0;
      data_q     <= '0;
      hdr_vld_q  <= 1'b0;
      dshift_q   <= 1'b0;
      word_vld_q <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      hdr_q      <= hdr_n;
      data_q     <= data_n;
      hdr_vld_q  <= hdr_vld_n;
      dshift_q   <= dshift_n;
      word_vld_q <= word_vld_n;
    end
  end

  assign hdr_vld_o  = hdr_vld_q;
  assign hdr_o      = hdr_q;
  assign dshift_o   = dshift_q;
  assign word_vld_o = word_vld_q;
  assign data_o     = data_q;
endmodule

// File: rtl/sdac_nv_port.sv
module sdac_nv_port
  import sdac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go_i,
  input  logic              wr_go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic              nv_req_o,
  output logic              nv_we_o,
  output logic [ADDR_W-1:0] nv_addr_o,
  output logic [CODE_W-1:0] nv_wdata_o,
  input  logic [CODE_W-1:0] nv_rdata_i,
  input  logic              nv_ack_i,
  output logic              fetch_done_o,
  output logic              fetch_vld_o,
  output logic [CODE_W-1:0] fetch_data_o
);
  logic              busy_q, busy_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CODE_W-1:0] wdata_q, wdata_n;
  logic              fdone_q, fdone_n;
  logic              fvld_q, fvld_n;
  logic [CODE_W-1:0] fdata_q, fdata_n;

  always_comb begin
    busy_n  = busy_q;
    we_n    = we_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    fdone_n = 1'b0;
    fvld_n  = fvld_q;
    fdata_n = fdata_q;
    if (!busy_q) begin
      if (rd_go_i) begin
        busy_n = 1'b1;
        we_n   = 1'b0;
        addr_n = addr_i;
        fvld_n = 1'b0;
      end else if (wr_go_i) begin
        busy_n  = 1'b1;
        we_n    = 1'b1;
        addr_n  = addr_i;
        wdata_n = wdata_i;
      end
    end else if (nv_ack_i) begin
      busy_n = 1'b0;
      if (!we_q) begin
        fdata_n = nv_rdata_i;
        fdone_n = 1'b1;
        fvld_n  = 1'b1;
      end
    end
    if (clr_i) begin
      fvld_n  = 1'b0;
      fdone_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      fdone_q <= 1'b0;
      fvld_q  <= 1'b0;
      fdata_q <= '0;
    end else begin
      busy_q  <= busy_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      fdone_q <= fdone_n;
      fvld_q  <= fvld_n;
      fdata_q <= fdata_n;
    end
  end

  assign nv_req_o     = busy_q;
  assign nv_we_o      = we_q;
  assign nv_addr_o    = addr_q;
  assign nv_wdata_o   = wdata_q;
  assign fetch_done_o = fdone_q;
  assign fetch_vld_o  = fvld_q;
  assign fetch_data_o = fdata_q;
endmodule

// File: rtl/sdac_live_regs.sv
module sdac_live_regs
  import sdac_cmd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CODE_W-1:0]        data_i,
  input  logic                     mute_all_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH*2-1:0]      state_o,
  output logic                     all_off_o
);
  logic [CODE_W-1:0] ctrl_q;
  logic              ctrl_en;
  logic [NUM_CH-1:0] shd_flags, mute_flags;

  assign ctrl_en    = we_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign shd_flags  = ctrl_q[NUM_CH-1:0];
  assign mute_flags = ctrl_q[2*NUM_CH-1:NUM_CH];
  assign all_off_o  = &(shd_flags | mute_flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= data_i;
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CODE_W-1:0] code_q;
      logic              code_en;
      ch_state_e         st;

      assign code_en = we_i && (addr_i == ADDR_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (code_en) code_q <= data_i;
      end

      always_comb begin
        if (shd_flags[c])                     st = CH_HIZ;
        else if (mute_flags[c] || mute_all_i) st = CH_MUTED;
        else                                  st = CH_ACTIVE;
      end

      assign code_o[c*CODE_W +: CODE_W] = code_q;
      assign state_o[c*2 +: 2]          = st;
    end
  endgenerate
endmodule

// File: rtl/sdac_serial_decoder.sv
module sdac_serial_decoder
  import sdac_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     csn_i,
  input  logic                     sdi_i,
  input  logic                     mute_all_i,
  output logic                     sdo_o,
  output logic                     sdo_oe_o,
  output logic                     nv_req_o,
  output logic                     nv_we_o,
  output logic [ADDR_W-1:0]        nv_addr_o,
  output logic [CODE_W-1:0]        nv_wdata_o,
  input  logic [CODE_W-1:0]        nv_rdata_i,
  input  logic                     nv_ack_i,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o,
  output logic [NUM_CH*2-1:0]      ch_state_o
);
  logic [2:0]        pins_s;
  logic              csn_s, sclk_s, sdi_s;
  logic              hdr_vld, dshift, word_vld;
  hdr_t              hdr;
  logic [CODE_W-1:0] rx_data;
  logic              hdr_ok, is_read;
  logic              rd_go, wr_go;
  logic              fetch_done, fetch_vld;
  logic [CODE_W-1:0] fetch_data;
  logic              lw_we;
  logic [CODE_W-1:0] lw_data;
  logic              all_off;
  logic              oe_q, oe_n;
  logic [CODE_W-1:0] osh_q, osh_n;

  sdac_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({csn_i, sclk_i, sdi_i}),
    .q_o(pins_s)
  );
  assign csn_s  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  sdac_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .hdr_vld_o(hdr_vld), .hdr_o(hdr), .dshift_o(dshift),
    .word_vld_o(word_vld), .data_o(rx_data)
  );

  assign hdr_ok  = hdr.start && (hdr.addr <= ADDR_W'(CTRL_ADDR));
  assign is_read = hdr_ok && (hdr.op == OP_READ);
  assign rd_go   = hdr_vld && hdr_ok && ((hdr.op == OP_READ) || (hdr.op == OP_LOAD));
  assign wr_go   = word_vld && hdr_ok && (hdr.op == OP_STORE) && !all_off;

  always_comb begin
    lw_we   = 1'b0;
    lw_data = rx_data;
    if (word_vld && hdr_ok) begin
      if (hdr.op == OP_WRITE) begin
        lw_we = 1'b1;
      end else if ((hdr.op == OP_LOAD) && fetch_vld) begin
        lw_we   = 1'b1;
        lw_data = fetch_data;
      end
    end
  end

  sdac_nv_port u_nv (
    .clk(clk), .rst_n(rst_n),
    .rd_go_i(rd_go), .wr_go_i(wr_go),
    .addr_i(hdr.addr), .wdata_i(rx_data), .clr_i(csn_s),
    .nv_req_o(nv_req_o), .nv_we_o(nv_we_o), .nv_addr_o(nv_addr_o),
    .nv_wdata_o(nv_wdata_o), .nv_rdata_i(nv_rdata_i), .nv_ack_i(nv_ack_i),
    .fetch_done_o(fetch_done), .fetch_vld_o(fetch_vld), .fetch_data_o(fetch_data)
  );

  sdac_live_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(lw_we), .addr_i(hdr.addr), .data_i(lw_data),
    .mute_all_i(mute_all_i),
    .code_o(dac_code_o), .state_o(ch_state_o), .all_off_o(all_off)
  );

  always_comb begin
    oe_n  = oe_q;
    osh_n = osh_q;
    if (csn_s) begin
      oe_n = 1'b0;
    end else if (fetch_done && is_read) begin
      oe_n  = 1'b1;
      osh_n = fetch_data;
    end else if (dshift && oe_q) begin
      osh_n = {osh_q[CODE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      osh_q <= '0;
    end else begin
      oe_q  <= oe_n;
      osh_q <= osh_n;
    end
  end

  assign sdo_oe_o = oe_q;
  assign sdo_o    = osh_q[CODE_W-1];
endmodule

// File: rtl/sdac_serial_decoder_chk.sv
module sdac_serial_decoder_chk
  import sdac_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     csn_i,
  input logic                     mute_all_i,
  input logic                     sdo_oe_o,
  input logic                     nv_req_o,
  input logic                     nv_we_o,
  input logic [ADDR_W-1:0]        nv_addr_o,
  input logic                     nv_ack_i,
  input logic [NUM_CH*CODE_W-1:0] dac_code_o,
  input logic [NUM_CH*2-1:0]      ch_state_o
);
  localparam int IDLE_LIM = SYNC_STAGES + 4;
  localparam int IC_W     = $clog2(IDLE_LIM + 1) + 1;

  logic [IC_W-1:0] idle_cnt;
  logic            idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idle_cnt <= '0;
    else if (!csn_i)                     idle_cnt <= '0;
    else if (idle_cnt < IC_W'(IDLE_LIM)) idle_cnt <= idle_cnt + 1'b1;
  end
  assign idle = (idle_cnt >= IC_W'(IDLE_LIM));

  assert_oe_off_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sdo_oe_o);

  assert_codes_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(dac_code_o));

  assert_req_held_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req_o && !nv_ack_i) |=> (nv_req_o && $stable(nv_addr_o) && $stable(nv_we_o)));

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assert_no_active_under_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mute_all_i |-> (ch_state_o[c*2 +: 2] != CH_ACTIVE));
      assert_state_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ch_state_o[c*2 +: 2] != 2'b11);
    end
  endgenerate
endmodule

bind sdac_serial_decoder sdac_serial_decoder_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .mute_all_i(mute_all_i),
  .sdo_oe_o(sdo_oe_o), .nv_req_o(nv_req_o), .nv_we_o(nv_we_o),
  .nv_addr_o(nv_addr_o), .nv_ack_i(nv_ack_i),
  .dac_code_o(dac_code_o), .ch_state_o(ch_state_o)
);

// File: tb/tb_sdac_serial_decoder.sv
module tb_sdac_serial_decoder;
  localparam int HALF = 10;
  localparam int K_CODE = 0, K_STATE = 1, K_RD = 2, K_OE = 3, K_REQ = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk, rst_n, sclk, csn, sdi, mute_all;
  logic        sdo, sdo_oe, nv_req, nv_we, nv_ack;
  logic [2:0]  nv_addr;
  logic [7:0]  nv_wdata, nv_rdata;
  logic [31:0] dac_code;
  logic [7:0]  ch_state;

  logic [7:0]  nvm [8];
  int          dly;
  logic [7:0]  rd_cap;
  logic [7:0]  exp_code [4];
  item_t       sb_q [$];
  event        obs_ev;
  int          n_chk, n_bad;
  bit          done;

  sdac_serial_decoder dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .mute_all_i(mute_all), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .nv_req_o(nv_req), .nv_we_o(nv_we), .nv_addr_o(nv_addr),
    .nv_wdata_o(nv_wdata), .nv_rdata_i(nv_rdata), .nv_ack_i(nv_ack),
    .dac_code_o(dac_code), .ch_state_o(ch_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // persistent store model: acknowledge three cycles after a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvm[0] <= 8'h3C; nvm[1] <= 8'hA6; nvm[2] <= 8'h12; nvm[3] <= 8'h40;
      nvm[4] <= 8'h08; nvm[5] <= 8'h00; nvm[6] <= 8'h00; nvm[7] <= 8'h00;
      nv_ack <= 1'b0; nv_rdata <= 8'h00; dly <= 0;
    end else if (nv_req && !nv_ack) begin
      if (dly == 2) begin
        nv_ack <= 1'b1;
        dly    <= 0;
        if (nv_we) nvm[nv_addr] <= nv_wdata;
        else       nv_rdata     <= nvm[nv_addr];
      end else begin
        dly <= dly + 1;
      end
    end else begin
      nv_ack <= 1'b0;
    end
  end

  function automatic logic [13:0] mk(input logic st, input logic [1:0] op,
                                     input logic [2:0] a, input logic [7:0] d);
    return {st, op, a, d};
  endfunction

  function automatic logic [31:0] codes_flat();
    return {exp_code[3], exp_code[2], exp_code[1], exp_code[0]};
  endfunction

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic observe();
    @(negedge clk);
    -> obs_ev;
    @(negedge clk);
  endtask

  // monitor: pop expected items and compare with what the design shows
  initial begin
    forever begin
      @(obs_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          K_CODE:  got = dac_code;
          K_STATE: got = {24'h0, ch_state};
          K_RD:    got = {24'h0, rd_cap};
          K_OE:    got = {31'h0, sdo_oe};
          default: got = {31'h0, nv_req};
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic send_bits(input logic [15:0] w, input int n);
    repeat (4) @(negedge clk);
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = w[n-1-i];
      repeat (HALF - 1) @(negedge clk);
      if (i >= 6) rd_cap[13-i] = sdo;
      @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [13:0] w);
    send_bits({2'b00, w}, 14);
  endtask

  task automatic toggle_deselected(input logic [13:0] w);
    for (int i = 0; i < 14; i++) begin
      sdi = w[13-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (16) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0; mute_all = 1'b0;
    rd_cap = 8'h00;
    for (int c = 0; c < 4; c++) exp_code[c] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    push(K_CODE, 32'h0, "R12 codes");
    push(K_STATE, 32'h0, "R12 states");
    push(K_OE, 32'h0, "R12 sdo_oe");
    push(K_REQ, 32'h0, "R12 nv_req");
    observe();

    // R2 live code writes
    send(mk(1'b1, 2'b01, 3'd0, 8'h5A)); exp_code[0] = 8'h5A;
    send(mk(1'b1, 2'b01, 3'd2, 8'hC3)); exp_code[2] = 8'hC3;
    push(K_CODE, codes_flat(), "R2 write ch0/ch2");
    observe();

    // R1 zero start bit discarded
    send(mk(1'b0, 2'b01, 3'd1, 8'hFF));
    push(K_CODE, codes_flat(), "R1 start=0 discarded");
    observe();

    // R10 unused address, truncated frame
    send(mk(1'b1, 2'b01, 3'd5, 8'hFF));
    send(mk(1'b1, 2'b01, 3'd7, 8'h00));
    push(K_CODE, codes_flat(), "R10 address 5/7 no-op");
    push(K_STATE, 32'h0, "R10 address 5/7 state");
    observe();
    send_bits({2'b00, mk(1'b1, 2'b01, 3'd1, 8'hEE)} >> 4, 10);
    push(K_CODE, codes_flat(), "R10 short frame");
    observe();

    // R11 clock edges while deselected
    toggle_deselected(mk(1'b1, 2'b01, 3'd3, 8'h81));
    push(K_CODE, codes_flat(), "R11 deselected edges");
    observe();

    // R3 control byte: mute ch1 (bit5), shut down ch2 (bit2)
    send(mk(1'b1, 2'b01, 3'd4, 8'h24));
    push(K_STATE, 32'h24, "R3 mute ch1 shdn ch2");
    push(K_CODE, codes_flat(), "R4 codes kept under flags");
    observe();

    // R4 shutdown over mute on ch2
    send(mk(1'b1, 2'b01, 3'd4, 8'h44));
    push(K_STATE, 32'h20, "R4 shutdown priority");
    observe();
    send(mk(1'b1, 2'b01, 3'd4, 8'h00));
    push(K_STATE, 32'h00, "R4 flags cleared");
    push(K_CODE, codes_flat(), "R4 codes return");
    observe();

    // R5 asynchronous mute
    mute_all = 1'b1;
    repeat (2) @(negedge clk);
    push(K_STATE, 32'h55, "R5 mute_all");
    observe();
    send(mk(1'b1, 2'b01, 3'd4, 8'h01));
    push(K_STATE, 32'h56, "R5 mute_all with shdn ch0");
    observe();
    mute_all = 1'b0;
    send(mk(1'b1, 2'b01, 3'd4, 8'h00));
    push(K_STATE, 32'h00, "R5 mute released");
    observe();

    // R6 store then R8 read back
    send(mk(1'b1, 2'b00, 3'd3, 8'h77));
    push(K_CODE, codes_flat(), "R6 store leaves live codes");
    push(K_REQ, 32'h0, "R6 request retired");
    observe();
    send(mk(1'b1, 2'b10, 3'd3, 8'h00));
    push(K_RD, 32'h77, "R8 read stored ch3");
    push(K_OE, 32'h0, "R8 sdo_oe after select");
    observe();
    send(mk(1'b1, 2'b10, 3'd1, 8'hFF));
    push(K_RD, 32'hA6, "R8 read preset ch1");
    push(K_CODE, codes_flat(), "R8 read leaves codes");
    observe();

    // R9 load
    send(mk(1'b1, 2'b11, 3'd1, 8'h00)); exp_code[1] = 8'hA6;
    push(K_CODE, codes_flat(), "R9 load ch1");
    observe();
    send(mk(1'b1, 2'b10, 3'd1, 8'h00));
    push(K_RD, 32'hA6, "R9 store unchanged by load");
    observe();
    send(mk(1'b1, 2'b11, 3'd4, 8'hFF));
    push(K_STATE, 32'h80, "R9 load control byte");
    observe();

    // R7 store dropped when all channels off
    send(mk(1'b1, 2'b01, 3'd4, 8'hF0));
    send(mk(1'b1, 2'b00, 3'd0, 8'h99));
    send(mk(1'b1, 2'b10, 3'd0, 8'h00));
    push(K_RD, 32'h3C, "R7 store ignored when all muted");
    observe();
    send(mk(1'b1, 2'b01, 3'd4, 8'h00));
    send(mk(1'b1, 2'b00, 3'd0, 8'h99));
    send(mk(1'b1, 2'b10, 3'd0, 8'h00));
    push(K_RD, 32'h99, "R7 store accepted after unmute");
    push(K_CODE, codes_flat(), "R6 codes after stores");
    observe();

    repeat (5) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule